// File: doc/BRIEF.md
# T1 Alarm Insertion and Loopback

This block is a bit-serial steering stage for a T1 framer with 193-bit frames. It sits between the receive framer and the system-side receive output. It chooses what leaves toward the system: the received bits or an all-ones alarm indication signal (AIS). It also chooses what leaves toward the line transmitter: the system transmit stream, or the received stream looped back as a payload loop. One bit is handled per clock. Each output is registered once, so it lags its inputs by one cycle.

A position counter tracks the frame. The frame-bit strobe forces it to position 0, and otherwise it runs freely. Loopback, transparency, automatic remote alarm and the automatic-AIS disable are sampled only at position 0, so a change to any of them never splits a frame. Forced AIS bypasses that sampling and acts on the next cycle. When automatic remote alarm is on, it sets a fixed bit position (parameter `RA_POS`, default 2) in the line stream while the receiver reports loss of frame alignment.

Top module: `t1_alarm_loop`

## Requirements
- R1: The bit position is 0 in any cycle where `fb_strobe_i` is high. Otherwise it is the previous position plus one, and it wraps from 192 back to 0. Position 0 carries the framing bit.
- R2: While the sampled automatic-AIS disable is 0 and `rx_sync_i` is 0, `sys_data_o` is 1 in the following cycle.
- R3: `send_ais_i` high makes `sys_data_o` 1 in the following cycle. This holds whatever the automatic-AIS disable is, and it does not wait for a frame boundary.
- R4: When no AIS applies, `sys_data_o` equals `rx_data_i` from one cycle earlier.
- R5: Without loopback, `line_data_o` equals `tx_data_i` from one cycle earlier, except where R8 inserts the alarm bit.
- R6: In loopback with transparency on, `line_data_o` equals `rx_data_i` from one cycle earlier at all 193 positions. The R8 position is included, and `tx_data_i` has no effect.
- R7: In loopback with transparency off, position 0 carries the value of `tx_fbit_i` sampled at the most recent strobe. The other positions carry `rx_data_i` (subject to R8), and `tx_data_i` has no effect.
- R8: While the sampled automatic remote alarm is on and `rx_sync_i` is 0, `ra_o` is 1 and the bit at position `RA_POS` (2) of `line_data_o` is 1, unless the loop is transparent. While `rx_sync_i` is 1, `ra_o` is 0 and nothing is inserted.
- R9: `lfa_o` is the inverse of `rx_sync_i` from one cycle earlier.
- R10: `loop_en_i`, `transp_i`, `auto_ra_i` and `ais_dis_i` are used only from the cycle at position 0. A change at any other position takes effect at the next position 0.
- R11: Reset drives all outputs to 0, sets the position to 0 and clears every sampled control. After reset, loopback is off and automatic AIS is enabled until the next position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 1 | Received bit from the framer |
| fb_strobe_i | input | 1 | Marks the framing-bit position of the current bit |
| rx_sync_i | input | 1 | Receiver is in frame sync |
| tx_data_i | input | 1 | System transmit bit |
| tx_fbit_i | input | 1 | Framing bit from the transmit framer, sampled at the strobe |
| ais_dis_i | input | 1 | Disables automatic AIS |
| send_ais_i | input | 1 | Forces AIS toward the system at once |
| loop_en_i | input | 1 | Enables payload loopback |
| transp_i | input | 1 | Loops all 193 bits, framing bit included |
| auto_ra_i | input | 1 | Enables automatic remote alarm |
| sys_data_o | output | 1 | System-side receive bit |
| line_data_o | output | 1 | Transmit-side line bit |
| lfa_o | output | 1 | Loss of frame alignment |
| ra_o | output | 1 | Remote alarm active |

## Verification
The assertions take `RA_POS` to be nonzero, so the alarm bit never shares position 0 with the framing bit. They also take `fb_strobe_i` to be the only thing that can pull the counter back to 0. The stimulus pulses the strobe once per frame, except in one stretch where the counter is left to wrap on its own for three frames. It changes controls at mid-frame only in a dedicated sweep, where the expected values keep the old settings until position 0. `send_ais_i` is pulsed inside a frame so that the immediate path is exercised apart from the frame-sampled ones.

// File: rtl/t1ai_pkg.sv
package t1ai_pkg;
  typedef struct packed {
    logic loop_en;
    logic transp;
    logic auto_ra;
    logic ais_dis;
  } t1ai_cfg_t;
endpackage

// File: rtl/t1ai_bit_pos.sv
module t1ai_bit_pos #(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned PW = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  output logic [PW-1:0] cur_pos_o,
  output logic          boundary_o
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [PW-1:0] pos_q;

  always_comb begin
    if (strobe_i)           cur_pos_o = '0;
    else if (pos_q == LAST) cur_pos_o = '0;
    else                    cur_pos_o = pos_q + 1'b1;
  end

  assign boundary_o = (cur_pos_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= cur_pos_o;
  end

  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= LAST); // R1
  AST_POS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && pos_q != LAST) |=> (pos_q == $past(pos_q) + 1'b1)); // R1
  AST_POS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (pos_q == '0)); // R1
endmodule

// File: rtl/t1ai_cfg_latch.sv
module t1ai_cfg_latch
  import t1ai_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boundary_i,
  input  t1ai_cfg_t  cfg_i,
  output t1ai_cfg_t  cfg_o
);
  t1ai_cfg_t cfg_q;

  // new settings apply from the boundary bit itself
  assign cfg_o = boundary_i ? cfg_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_o;
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/t1ai_sys_path.sv
module t1ai_sys_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_data_i,
  input  logic send_ais_i,
  input  logic ais_dis_i,
  input  logic rx_sync_i,
  output logic sys_data_o,
  output logic lfa_o
);
  logic ais_now;

  assign ais_now = send_ais_i | (~ais_dis_i & ~rx_sync_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_data_o <= 1'b0;
      lfa_o      <= 1'b0;
    end else begin
      sys_data_o <= ais_now | rx_data_i;
      lfa_o      <= ~rx_sync_i;
    end
  end

  AST_SEND_AIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_ais_i |=> sys_data_o); // R3
  AST_AUTO_AIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ais_dis_i && !rx_sync_i) |=> sys_data_o); // R2
  AST_RX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!send_ais_i && (ais_dis_i || rx_sync_i)) |=> (sys_data_o == $past(rx_data_i))); // R4
  AST_LFA_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (lfa_o != $past(rx_sync_i))); // R9
endmodule

// File: rtl/t1ai_line_path.sv
module t1ai_line_path
  import t1ai_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned PW = $clog2(FRAME_BITS),
  parameter int unsigned RA_POS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] cur_pos_i,
  input  logic          strobe_i,
  input  t1ai_cfg_t     cfg_i,
  input  logic          rx_data_i,
  input  logic          tx_data_i,
  input  logic          tx_fbit_i,
  input  logic          rx_sync_i,
  output logic          line_data_o,
  output logic          ra_o
);
  localparam logic [PW-1:0] RA_IDX = PW'(RA_POS);

  logic fbit_q, fbit_d;
  logic transp_loop, ra_act, ra_hit, nxt_bit;

  assign fbit_d      = strobe_i ? tx_fbit_i : fbit_q;
  assign transp_loop = cfg_i.loop_en & cfg_i.transp;
  assign ra_act      = cfg_i.auto_ra & ~rx_sync_i;
  assign ra_hit      = ra_act & (cur_pos_i == RA_IDX) & ~transp_loop;

  always_comb begin
    if (!cfg_i.loop_en)                          nxt_bit = tx_data_i;
    else if (!cfg_i.transp && cur_pos_i == '0)   nxt_bit = fbit_d;
    else                                         nxt_bit = rx_data_i;
    if (ra_hit) nxt_bit = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_data_o <= 1'b0;
      ra_o        <= 1'b0;
      fbit_q      <= 1'b0;
    end else begin
      line_data_o <= nxt_bit;
      ra_o        <= ra_act;
      fbit_q      <= fbit_d;
    end
  end

  AST_LOOP_TRANSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.loop_en && cfg_i.transp) |=> (line_data_o == $past(rx_data_i))); // R6
  AST_NO_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.loop_en && !(cfg_i.auto_ra && !rx_sync_i && cur_pos_i == RA_IDX))
      |=> (line_data_o == $past(tx_data_i))); // R5
  AST_FBIT_GEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RA_POS != 0 && cfg_i.loop_en && !cfg_i.transp && strobe_i)
      |=> (line_data_o == $past(tx_fbit_i))); // R7
  AST_RA_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.auto_ra && !rx_sync_i && cur_pos_i == RA_IDX && !(cfg_i.loop_en && cfg_i.transp))
      |=> (line_data_o && ra_o)); // R8
  AST_RA_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sync_i |=> !ra_o); // R8
endmodule

// File: rtl/t1_alarm_loop.sv
module t1_alarm_loop
  import t1ai_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned RA_POS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_data_i,
  input  logic fb_strobe_i,
  input  logic rx_sync_i,
  input  logic tx_data_i,
  input  logic tx_fbit_i,
  input  logic ais_dis_i,
  input  logic send_ais_i,
  input  logic loop_en_i,
  input  logic transp_i,
  input  logic auto_ra_i,
  output logic sys_data_o,
  output logic line_data_o,
  output logic lfa_o,
  output logic ra_o
);
  localparam int unsigned PW = $clog2(FRAME_BITS);

  logic [PW-1:0] cur_pos;
  logic          boundary;
  t1ai_cfg_t     cfg_in, cfg_eff;

  assign cfg_in = '{loop_en: loop_en_i, transp: transp_i,
                    auto_ra: auto_ra_i, ais_dis: ais_dis_i};

  t1ai_bit_pos #(.FRAME_BITS(FRAME_BITS), .PW(PW)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (fb_strobe_i),
    .cur_pos_o  (cur_pos),
    .boundary_o (boundary)
  );

  t1ai_cfg_latch u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary),
    .cfg_i      (cfg_in),
    .cfg_o      (cfg_eff)
  );

  t1ai_sys_path u_sys (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_data_i  (rx_data_i),
    .send_ais_i (send_ais_i),
    .ais_dis_i  (cfg_eff.ais_dis),
    .rx_sync_i  (rx_sync_i),
    .sys_data_o (sys_data_o),
    .lfa_o      (lfa_o)
  );

  t1ai_line_path #(.FRAME_BITS(FRAME_BITS), .PW(PW), .RA_POS(RA_POS)) u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_pos_i   (cur_pos),
    .strobe_i    (fb_strobe_i),
    .cfg_i       (cfg_eff),
    .rx_data_i   (rx_data_i),
    .tx_data_i   (tx_data_i),
    .tx_fbit_i   (tx_fbit_i),
    .rx_sync_i   (rx_sync_i),
    .line_data_o (line_data_o),
    .ra_o        (ra_o)
  );

  AST_SEND_AIS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_ais_i && ais_dis_i) |=> sys_data_o); // R3
endmodule

// File: tb/t1_alarm_loop_tb.sv
`timescale 1ns/1ps
module t1_alarm_loop_tb;
  localparam int FB = 193;
  localparam int RAP = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_data_i = 0, fb_strobe_i = 0, rx_sync_i = 0, tx_data_i = 0, tx_fbit_i = 0;
  logic ais_dis_i = 0, send_ais_i = 0, loop_en_i = 0, transp_i = 0, auto_ra_i = 0;
  logic sys_data_o, line_data_o, lfa_o, ra_o;

  always #2.5 clk_i = ~clk_i;

  t1_alarm_loop #(.FRAME_BITS(FB), .RA_POS(RAP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_data_i(rx_data_i), .fb_strobe_i(fb_strobe_i),
    .rx_sync_i(rx_sync_i), .tx_data_i(tx_data_i), .tx_fbit_i(tx_fbit_i),
    .ais_dis_i(ais_dis_i), .send_ais_i(send_ais_i), .loop_en_i(loop_en_i),
    .transp_i(transp_i), .auto_ra_i(auto_ra_i), .sys_data_o(sys_data_o),
    .line_data_o(line_data_o), .lfa_o(lfa_o), .ra_o(ra_o)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;
  int   m_pos = 0;
  logic m_lp = 0, m_tr = 0, m_ra = 0, m_dis = 0, m_fbit = 0;

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  // called just after a falling edge
  task automatic step(input logic stb, input logic sync, input logic sais, input logic lp,
                      input logic tr, input logic ara, input logic adis, input logic fb,
                      input string grp);
    int cur;
    logic fbd, e_sys, e_line;
    string t_sys, t_line;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rx_data_i = lfsr[0]; tx_data_i = lfsr[7];
    fb_strobe_i = stb; rx_sync_i = sync; send_ais_i = sais; loop_en_i = lp;
    transp_i = tr; auto_ra_i = ara; ais_dis_i = adis; tx_fbit_i = fb;
    cur = stb ? 0 : ((m_pos == FB - 1) ? 0 : m_pos + 1);          // R1
    if (cur == 0) begin m_lp = lp; m_tr = tr; m_ra = ara; m_dis = adis; end  // R10
    fbd = stb ? fb : m_fbit;
    m_fbit = fbd;
    if (sais) begin e_sys = 1'b1; t_sys = "R3"; end
    else if (!m_dis && !sync) begin e_sys = 1'b1; t_sys = "R2"; end
    else begin e_sys = rx_data_i; t_sys = "R4"; end
    if (m_lp && m_tr) begin e_line = rx_data_i; t_line = "R6"; end
    else if (m_lp) begin e_line = (cur == 0) ? fbd : rx_data_i; t_line = "R7"; end
    else begin e_line = tx_data_i; t_line = "R5"; end
    if (m_ra && !sync && cur == RAP && !(m_lp && m_tr)) begin e_line = 1'b1; t_line = "R8"; end
    if (grp == "R10" || grp == "R11") begin t_sys = grp; t_line = grp; end
    if (grp == "R1" && cur == 0) t_line = "R1";
    m_pos = cur;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(t_sys, "sys_data_o", sys_data_o, e_sys);
    chk(t_line, "line_data_o", line_data_o, e_line);
    chk("R9", "lfa_o", lfa_o, ~sync);
    chk("R8", "ra_o", ra_o, m_ra & ~sync);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    rx_data_i = 1; tx_data_i = 1; rx_sync_i = 0; send_ais_i = 1; loop_en_i = 1;
    auto_ra_i = 1; fb_strobe_i = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    // R11: all outputs low under reset
    chk("R11", "sys_data_o", sys_data_o, 1'b0);
    chk("R11", "line_data_o", line_data_o, 1'b0);
    chk("R11", "lfa_o", lfa_o, 1'b0);
    chk("R11", "ra_o", ra_o, 1'b0);
    rst_ni = 1'b1;
    m_pos = 0; m_lp = 0; m_tr = 0; m_ra = 0; m_dis = 0; m_fbit = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    // R11: sampled controls cleared until the next position 0
    step(0, 0, 0, 1, 1, 1, 1, 1, "R11");
    step(0, 0, 0, 1, 0, 1, 1, 0, "R11");
    // sweep every control combination, sync state and AIS pulse
    for (int f = 0; f < 64; f++) begin
      logic [5:0] fv;
      fv = 6'(f);
      for (int b = 0; b < FB; b++)
        step(b == 0, fv[4], fv[5] && b >= 50 && b <= 60, fv[0], fv[1], fv[2], fv[3],
             1'((f + b) % 2), "");
    end
    // R10: controls flipped mid-frame
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cv;
      for (int b = 0; b < FB; b++) begin
        cv = (b < 100) ? 4'(c) : ~4'(c);
        step(b == 0, 0, 0, cv[0], cv[1], cv[2], cv[3], 1'(c % 2), "R10");
      end
    end
    // R1: free-running wrap, framing bit kept from the single strobe
    step(1, 1, 0, 1, 0, 0, 1, 1, "R1");
    for (int b = 1; b < 3 * FB + 2; b++) step(0, 1, 0, 1, 0, 0, 1, 0, "R1");
    // R11: reset in mid-run
    do_reset();
    step(0, 0, 0, 1, 1, 1, 1, 1, "R11");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule